// File: doc/BRIEF.md
# Video Memory Contention Delay Generator

This block decides how long a CPU memory cycle has to be held off while the video logic owns the shared display RAM. It keeps its own frame T-state counter, which the interrupt restarts. From that counter it derives a line position and a display-line index. These give the point in the frame that the current T-state occupies. When a memory cycle begins on a contended address inside the active part of a display line, the block reports a wait count that depends on the position, and it holds the CPU clock-enable low for exactly that many T-states.

Four machine flavours are supported, and the `model` input selects one. They differ in where the display window starts, in the line length, in the shape of the descending wait pattern, in which upper RAM banks are contended, and in whether the memory-request strobe gates the contention. A late-timing option moves the window one T-state later on the flavours whose video chip drifts. One clock of `clk` equals one T-state.

Top module: `vc_contention_top`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `delay` is 0, `cpuWait` is 0 and `cpuEn` is 1. The frame T-state number of that first cycle is 0, and it increases by one per clock.
- R2: An address with `addr[15:14]` equal to 2'b00 or 2'b10 always gives `delay` 0. An address with `addr[15:14]` equal to 2'b01 is contended in every model.
- R3: An address with `addr[15:14]` equal to 2'b11 is contended only in model 1 when `upperBank[0]` is 1, and in model 2 when `upperBank[2]` is 1. It is never contended in models 0 and 3.
- R4: In model 0 (`model`=0), the window opens at T-state S=14335 and lines are 224 T-states long. At T-state S+224*L+p, with L<192 and p<128, a contended access gets delay 6-(p mod 8) when p mod 8 is below 6, and 0 otherwise. Every other T-state gives 0.
- R5: Model 1 uses the same pattern as R4, with S=14361 and a line length of 228.
- R6: In model 2, S=14361, lines are 228 T-states long and each line is active for p<129. The delay there is (1-p) mod 8, so the sequence runs 1,0,7,6,5,4,3,2,1,0,7 and so on.
- R7: Model 3 uses the pattern and line length of R4 with S=8959.
- R8: With `lateTiming` high, S grows by one in models 0, 1 and 3. Model 2 ignores `lateTiming`.
- R9: In model 2, a contended access gives delay 0 while `memReq` is low. In the other models, `memReq` has no effect.
- R10: The frame T-state number wraps to 0 after 69888 T-states in model 0, 70908 in models 1 and 2, and 59136 in model 3. A high `frameSync` makes the next T-state number 0.
- R11: When no stall is running and `cycleStart` is high with a nonzero `delay` D, `cpuWait` is high and `cpuEn` is low for exactly D consecutive cycles, starting in that cycle. `cycleStart` is ignored while a stall runs. A zero delay causes no stall.
- R12: The frame T-state count keeps advancing during a stall, so the delays that follow it still match R4 to R7 at their absolute T-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Interrupt pulse; the next T-state is number 0 |
| addr | input | 16 | CPU memory address |
| upperBank | input | 3 | RAM bank paged at 0xC000-0xFFFF |
| memReq | input | 1 | Memory-request strobe |
| cycleStart | input | 1 | High on the first T-state of a memory cycle |
| model | input | 2 | 0: 48K, 1: 128, 2: gate-array, 3: NTSC |
| lateTiming | input | 1 | Late video timing option |
| delay | output | 3 | Wait count for the current T-state and address |
| cpuWait | output | 1 | Stall in progress or starting |
| cpuEn | output | 1 | CPU clock enable, low while stalled |

## Verification
The assertions assume that `model` and `lateTiming` change only while reset is held, because the counters track one frame geometry at a time. They also assume that `addr` is meaningful whenever `cycleStart` is high. The stimulus applies each configuration under reset. It then sweeps many address regions, bank values and strobe levels, T-state by T-state, through whole display lines. The 48K run covers a complete frame and its natural wrap. A frame sync is also issued in the middle of a frame.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    MODEL_48K  = 2'd0,
    MODEL_128  = 2'd1,
    MODEL_GA   = 2'd2,
    MODEL_NTSC = 2'd3
  } model_e;

  localparam int FRAME_W = 17;
  localparam int POS_W   = 8;

  // Position information handed from the beam sequencer to the stall path.
  typedef struct packed {
    logic       patternOn;
    logic [2:0] phase;
  } slot_t;

  function automatic int frameLenOf(model_e m);
    case (m)
      MODEL_48K:  return 69888;
      MODEL_NTSC: return 59136;
      default:    return 70908;
    endcase
  endfunction

  function automatic int lineLenOf(model_e m);
    return (m == MODEL_48K || m == MODEL_NTSC) ? 224 : 228;
  endfunction

  function automatic int windowOf(model_e m);
    return (m == MODEL_GA) ? 129 : 128;
  endfunction

  function automatic int startOf(model_e m, logic late);
    int s;
    case (m)
      MODEL_48K:  s = 14335;
      MODEL_NTSC: s = 8959;
      default:    s = 14361;
    endcase
    if (late && m != MODEL_GA) s = s + 1;
    return s;
  endfunction

endpackage

// File: rtl/vc_beam_seq.sv
module vc_beam_seq
  import vc_pkg::*;
#(
  parameter int DISPLAY_LINES = 192
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   frameSync,
  input  model_e model,
  input  logic   lateTiming,
  output slot_t  slot
);
  localparam int LINE_W = (DISPLAY_LINES > 1) ? $clog2(DISPLAY_LINES) : 1;
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(DISPLAY_LINES - 1);

  logic [FRAME_W-1:0] frameCnt, frameNext, frameLast, startT;
  logic [POS_W-1:0]   linePos, lineLast, winLen;
  logic [LINE_W-1:0]  lineNum;
  logic               inDisp;

  always_comb begin
    frameLast = FRAME_W'(frameLenOf(model) - 1);
    startT    = FRAME_W'(startOf(model, lateTiming));
    lineLast  = POS_W'(lineLenOf(model) - 1);
    winLen    = POS_W'(windowOf(model));
    if (frameSync || frameCnt == frameLast) frameNext = '0;
    else                                    frameNext = frameCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCnt <= '0;
      linePos  <= '0;
      lineNum  <= '0;
      inDisp   <= 1'b0;
    end else begin
      frameCnt <= frameNext;
      if (frameNext == startT) begin
        linePos <= '0;
        lineNum <= '0;
        inDisp  <= 1'b1;
      end else if (frameSync) begin
        inDisp <= 1'b0;
      end else if (inDisp) begin
        if (linePos == lineLast) begin
          linePos <= '0;
          if (lineNum == LAST_LINE) inDisp <= 1'b0;
          else                      lineNum <= lineNum + 1'b1;
        end else begin
          linePos <= linePos + 1'b1;
        end
      end
    end
  end

  always_comb begin
    slot.patternOn = inDisp && (linePos < winLen);
    slot.phase     = linePos[2:0];
  end

  p_frame_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameCnt <= frameLast);

  p_display_after_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    inDisp |-> frameCnt >= startT);

  p_sync_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> frameCnt == '0);

endmodule

// File: rtl/vc_stall_path.sv
module vc_stall_path
  import vc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  slot_t       slot,
  input  model_e      model,
  input  logic [15:0] addr,
  input  logic [2:0]  upperBank,
  input  logic        memReq,
  input  logic        cycleStart,
  output logic [2:0]  delayVal,
  output logic        cpuWait,
  output logic        cpuEn
);
  logic       bankHit, contended, gateOk, busy, stallReq;
  logic [2:0] rawDelay, stallCnt;

  always_comb begin
    case (model)
      MODEL_128: bankHit = upperBank[0];
      MODEL_GA:  bankHit = upperBank[2];
      default:   bankHit = 1'b0;
    endcase
    contended = (addr[15:14] == 2'b01) || (addr[15:14] == 2'b11 && bankHit);
    gateOk    = (model != MODEL_GA) || memReq;
    if (model == MODEL_GA)   rawDelay = 3'd1 - slot.phase;
    else if (slot.phase < 6) rawDelay = 3'd6 - slot.phase;
    else                     rawDelay = 3'd0;
    delayVal = (slot.patternOn && contended && gateOk) ? rawDelay : 3'd0;
    busy     = (stallCnt != 3'd0);
    stallReq = cycleStart && !busy && (delayVal != 3'd0);
    cpuWait  = stallReq || busy;
    cpuEn    = !cpuWait;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         stallCnt <= 3'd0;
    else if (stallReq) stallCnt <= delayVal - 3'd1;
    else if (busy)     stallCnt <= stallCnt - 3'd1;
  end

  p_outside_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !slot.patternOn |-> delayVal == 3'd0);

  p_low_region_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr[14] == 1'b0) |-> delayVal == 3'd0);

  p_ga_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (model == MODEL_GA && !memReq) |-> delayVal == 3'd0);

  p_ula_max_r4: assert property (@(posedge clk) disable iff (!rstN)
    (model != MODEL_GA) |-> delayVal <= 3'd6);

  p_stall_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && cpuEn == 1'b0 && !busy) |=> stallCnt == $past(delayVal) - 3'd1);

  p_stall_count_r11: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> stallCnt == $past(stallCnt) - 3'd1);

endmodule

// File: rtl/vc_contention_top.sv
module vc_contention_top
  import vc_pkg::*;
#(
  parameter int DISPLAY_LINES = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameSync,
  input  logic [15:0] addr,
  input  logic [2:0]  upperBank,
  input  logic        memReq,
  input  logic        cycleStart,
  input  logic [1:0]  model,
  input  logic        lateTiming,
  output logic [2:0]  delay,
  output logic        cpuWait,
  output logic        cpuEn
);
  model_e modelSel;
  slot_t  slot;

  assign modelSel = model_e'(model);

  vc_beam_seq #(.DISPLAY_LINES(DISPLAY_LINES)) uSeq (
    .clk        (clk),
    .rstN       (rstN),
    .frameSync  (frameSync),
    .model      (modelSel),
    .lateTiming (lateTiming),
    .slot       (slot)
  );

  vc_stall_path uPath (
    .clk        (clk),
    .rstN       (rstN),
    .slot       (slot),
    .model      (modelSel),
    .addr       (addr),
    .upperBank  (upperBank),
    .memReq     (memReq),
    .cycleStart (cycleStart),
    .delayVal   (delay),
    .cpuWait    (cpuWait),
    .cpuEn      (cpuEn)
  );

endmodule

// File: tb/tb_vc_contention_top.sv
`timescale 1ns/1ps
module tb_vc_contention_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameSync = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [2:0]  upperBank = 3'd0;
  logic        memReq = 1'b0;
  logic        cycleStart = 1'b0;
  logic [1:0]  model = 2'd0;
  logic        lateTiming = 1'b0;
  logic [2:0]  delay;
  logic        cpuWait, cpuEn;

  int checks = 0, fails = 0;
  int t = 0, k = 0, rem = 0, frameNo = 0;
  int cycles = 0;
  bit done = 0;

  vc_contention_top dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .addr(addr),
    .upperBank(upperBank), .memReq(memReq), .cycleStart(cycleStart),
    .model(model), .lateTiming(lateTiming), .delay(delay),
    .cpuWait(cpuWait), .cpuEn(cpuEn)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 198000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic int fLen(int m);
    return (m == 0) ? 69888 : (m == 3) ? 59136 : 70908;
  endfunction

  function automatic int expDelay(int m, bit late, int tt, logic [15:0] a, int bank, bit mreq);
    int s, len, win, off, line, p;
    bit cont;
    cont = (a[15:14] == 2'b01) ||
           (a[15:14] == 2'b11 && ((m == 1 && bank % 2 == 1) || (m == 2 && bank >= 4)));
    if (!cont) return 0;
    if (m == 2 && !mreq) return 0;
    s = (m == 0) ? 14335 : (m == 3) ? 8959 : 14361;
    if (late && m != 2) s++;
    len = (m == 0 || m == 3) ? 224 : 228;
    win = (m == 2) ? 129 : 128;
    if (tt < s) return 0;
    off = tt - s; line = off / len; p = off % len;
    if (line >= 192 || p >= win) return 0;
    if (m == 2) return ((1 - p) % 8 + 8) % 8;
    return (p % 8 < 6) ? 6 - p % 8 : 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0d: actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  task automatic doReset(int m, bit late);
    rstN = 1'b0; model = 2'(m); lateTiming = late;
    cycleStart = 1'b0; frameSync = 1'b0; addr = 16'h4000; memReq = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(delay == 0 && cpuWait == 0 && cpuEn == 1, "R1 in reset", {cpuEn, cpuWait, delay}, 8);
    @(negedge clk);
    rstN = 1'b1; t = 0; rem = 0; frameNo = 0;
    #1;
    chk(delay == 0 && cpuWait == 0 && cpuEn == 1, "R1 after release", {cpuEn, cpuWait, delay}, 8);
  endtask

  task automatic step(int m, bit late, bit sync);
    int d, sel;
    bit expReq, expWait;
    string tag;
    sel = k % 6;
    case (sel)
      0, 1, 2: addr = 16'h4000 | 16'(k & 16'h3FFF);
      3:       addr = 16'h0000 | 16'(k & 16'h3FFF);
      4:       addr = 16'h8000 | 16'(k & 16'h3FFF);
      default: addr = 16'hC000 | 16'(k & 16'h3FFF);
    endcase
    upperBank  = 3'((k / 6) % 8);
    memReq     = (k % 7) != 0;
    cycleStart = (k % 13) == 0;
    frameSync  = sync;
    #1;
    d = expDelay(m, late, t, addr, int'(upperBank), memReq);
    if (frameNo > 0)               tag = "R10";
    else if (rem > 0)              tag = "R12";
    else if (sel == 3 || sel == 4) tag = "R2";
    else if (sel == 5)             tag = "R3";
    else if (m == 2 && !memReq)    tag = "R9";
    else if (late)                 tag = "R8";
    else tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
    chk(int'(delay) == d, tag, int'(delay), d);
    expReq  = cycleStart && rem == 0 && d != 0;
    expWait = expReq || rem > 0;
    chk(cpuWait == expWait && cpuEn == !expWait, "R11", {cpuWait, cpuEn}, {expWait, !expWait});
    @(posedge clk);
    if (rem > 0) rem--;
    else if (expReq) rem = d - 1;
    if (sync) t = 0;
    else if (t == fLen(m) - 1) begin t = 0; frameNo++; end
    else t++;
    k++;
    @(negedge clk);
    frameSync = 1'b0;
  endtask

  task automatic runCfg(int m, bit late, int n);
    doReset(m, late);
    for (int i = 0; i < n; i++) step(m, late, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    // R4, R10: full 48K frame, natural wrap, and two lines of the next frame
    runCfg(0, 1'b0, 69888 + 14335 + 2 * 224 + 10);
    // R5 and R8 on the 128 flavour
    runCfg(1, 1'b0, 14361 + 2 * 228 + 10);
    runCfg(1, 1'b1, 14362 + 2 * 228 + 10);
    // R6, R9, and R8 ignored on the gate-array flavour
    runCfg(2, 1'b0, 14361 + 2 * 228 + 10);
    runCfg(2, 1'b1, 14361 + 2 * 228 + 10);
    // R7 and a mid-frame sync (R10)
    runCfg(3, 1'b0, 9100);
    step(3, 1'b0, 1'b1);
    for (int i = 0; i < 8959 + 2 * 224 + 10; i++) step(3, 1'b0, 1'b0);
    runCfg(3, 1'b1, 8960 + 2 * 224 + 10);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule